// File: doc/BRIEF.md
# Hybrid TLB Entry Store with Write, Read and Fill Control

This block holds every entry of a two-part translation buffer and executes the three software maintenance operations on it: indexed write, indexed read and fill. The first part is set-associative (8 ways by 256 sets by default), and all of its entries use one page size supplied from outside. The second part is a small fully associative pool (64 entries by default), and each of its entries keeps its own page size. A single flat index covers both parts. Way `w` and set `s` of the set-associative part sit at `w*SETS + s`. The fully associative entries follow at `WAYS*SETS` and above.

Each operation takes the current staging values: a virtual address whose bits above the page offset form the page-pair number, two low words, an index, a page size, a not-exists flag and the current address-space id. When a refill-mode input is high, the address, page size and both low words come from a second, refill set of staging inputs instead. A read returns new staging values on its outputs. A fill picks its own victim. If the page size equals the shared size, the victim is a pseudo-random way in the set given by the address. Otherwise it is a pseudo-random entry of the fully associative pool. The block reports the chosen index.

Top module: `tlbw_ctrl`

## Requirements
- R1: After reset, `done` is low, the read outputs show `rd_ne`=1 with all other read fields zero, and every entry reads as not existing.
- R2: An accepted operation (`op_valid` high with `op_code` 0 = read, 1 = write or 2 = fill) raises `done` for exactly the following cycle. `done` is low in every other cycle.
- R3: A write with `stg_ne`=0 marks the entry at `stg_idx` as existing and stores VA bits 47:13, `cur_asid` and both low words. A later read returns `rd_ne`=0, `rd_hi` = stored page-pair number shifted left by 13, the stored address-space id and both low words.
- R4: A read of an entry that does not exist sets `rd_ne`=1 and zeroes `rd_asid`, `rd_hi`, `rd_lo0`, `rd_lo1` and `rd_ps`.
- R5: A read of a set-associative entry (index below 2048) returns the `shared_ps` present at the time of the read. A read of a fully associative entry returns the page size stored when it was written.
- R6: A write with `stg_ne`=1 only clears the exists bit of the addressed entry, so a following read of that entry reports it as not existing.
- R7: A fill whose page size equals `shared_ps` writes index way*256+set, where set = (VA >> (ps+1)) & 255 and the way is pseudo-random. The reported `fill_idx` is therefore below 2048 and has the set in bits 7:0.
- R8: A fill whose page size differs from `shared_ps` writes an entry with an index from 2048 to 2111.
- R9: With `refill_mode`=1, writes and fills take the address, page size and both low words from the `rf_*` inputs. The `stg_*` versions of these values are then unused.
- R10: The entry reported in `fill_idx` reads back with the filled address, address-space id, low words and page size.
- R11: A write to an index of 2112 or above changes no entry. A read of such an index reports not existing.
- R12: `op_code` 3 is ignored. The read outputs change only after an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 2 | 0 read, 1 write, 2 fill, 3 ignored |
| refill_mode | input | 1 | Take address, page size and low words from the refill inputs |
| cur_asid | input | 10 | Current address-space id |
| shared_ps | input | 6 | Page size shared by the set-associative part |
| stg_va | input | 48 | Staging virtual address |
| stg_lo0 | input | 64 | Staging low word for the even page |
| stg_lo1 | input | 64 | Staging low word for the odd page |
| stg_idx | input | 12 | Staging flat index for read and write |
| stg_ps | input | 6 | Staging page size |
| stg_ne | input | 1 | Staging not-exists flag |
| rf_va | input | 48 | Refill virtual address |
| rf_lo0 | input | 64 | Refill low word, even page |
| rf_lo1 | input | 64 | Refill low word, odd page |
| rf_ps | input | 6 | Refill page size |
| done | output | 1 | Operation completed in the previous cycle |
| fill_idx | output | 12 | Flat index chosen by the last fill |
| rd_ne | output | 1 | Read result: entry does not exist |
| rd_asid | output | 10 | Read result: address-space id |
| rd_hi | output | 48 | Read result: page-pair number shifted to address position |
| rd_lo0 | output | 64 | Read result: even low word |
| rd_lo1 | output | 64 | Read result: odd low word |
| rd_ps | output | 6 | Read result: page size |

## Verification
The checker assumes that `shared_ps`, `refill_mode` and the page-size inputs hold their values through the cycle an operation is sampled. It also assumes that page sizes stay small enough that `ps+1` is a legal shift of the 48-bit address. The stimulus changes staging values only between operations, always after a clock edge. It uses page sizes from 7 to 30. The fill victim is pseudo-random, so the bench does not predict the exact index. It checks the range and set from R7 and R8, then reads the entry back at the index the block reported.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_FILL  = 2'd2,
      OP_IDLE  = 2'd3
   } tlbw_op_e;

   localparam int DEF_WAYS     = 8;
   localparam int DEF_SETS     = 256;
   localparam int DEF_FA_N     = 64;
   localparam int DEF_VA_W     = 48;
   localparam int DEF_LO_W     = 64;
   localparam int DEF_ASID_W   = 10;
   localparam int DEF_PS_W     = 6;
   localparam int DEF_PAGE_LSB = 13;
   localparam int DEF_LFSR_W   = 16;
endpackage

// File: rtl/tlbw_lfsr.sv
module tlbw_lfsr #(
   parameter int LFSR_W = 16,
   parameter int OUT_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);
   logic [LFSR_W-1:0] taps;
   logic [LFSR_W-1:0] state_q;

   generate
      if (LFSR_W == 16) begin : g_w16
         assign taps = 16'hB400;
      end else if (LFSR_W == 32) begin : g_w32
         assign taps = 32'h8020_0003;
      end else begin : g_bad
         $error("tlbw_lfsr: LFSR_W must be 16 or 32");
      end
      if (OUT_W > LFSR_W) begin : g_chk_out
         $error("tlbw_lfsr: OUT_W exceeds LFSR_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LFSR_W'(1);
      end else begin
         state_q <= {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? taps : '0);
      end
   end

   assign rnd = state_q[OUT_W-1:0];
endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
   parameter int WAYS   = 8,
   parameter int SETS   = 256,
   parameter int FA_N   = 64,
   parameter int VA_W   = 48,
   parameter int PS_W   = 6,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int FA_W  = $clog2(FA_N),
   localparam int IDX_W = $clog2(WAYS*SETS + FA_N)
) (
   input  logic [VA_W-1:0]       va,
   input  logic [PS_W-1:0]       ps,
   input  logic [PS_W-1:0]       shared_ps,
   input  logic [WAY_W+FA_W-1:0] rnd,
   output logic [IDX_W-1:0]      idx
);
   localparam int SA_N = WAYS * SETS;

   logic [PS_W:0]      sh;
   logic [SET_W-1:0]   set_sel;
   logic [WAY_W-1:0]   way_sel;
   logic [FA_W-1:0]    fa_sel;

   always_comb begin
      sh      = {1'b0, ps} + (PS_W+1)'(1);
      set_sel = SET_W'(va >> sh);
      way_sel = rnd[WAY_W-1:0];
      fa_sel  = rnd[WAY_W +: FA_W];
      if (ps == shared_ps) begin
         idx = IDX_W'({way_sel, set_sel});
      end else begin
         idx = IDX_W'(SA_N) + IDX_W'(fa_sel);
      end
   end
endmodule

// File: rtl/tlbw_store.sv
module tlbw_store #(
   parameter int WAYS     = 8,
   parameter int SETS     = 256,
   parameter int FA_N     = 64,
   parameter int VPPN_W   = 35,
   parameter int ASID_W   = 10,
   parameter int LO_W     = 64,
   parameter int PS_W     = 6,
   localparam int IDX_W   = $clog2(WAYS*SETS + FA_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_clr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [VPPN_W-1:0] wr_vppn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [LO_W-1:0]   wr_lo0,
   input  logic [LO_W-1:0]   wr_lo1,
   input  logic [PS_W-1:0]   wr_ps,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_e,
   output logic              rd_fa,
   output logic [VPPN_W-1:0] rd_vppn,
   output logic [ASID_W-1:0] rd_asid,
   output logic [LO_W-1:0]   rd_lo0,
   output logic [LO_W-1:0]   rd_lo1,
   output logic [PS_W-1:0]   rd_ps
);
   localparam int SA_N = WAYS * SETS;
   localparam int TOT  = SA_N + FA_N;
   localparam int SA_W = $clog2(SA_N);
   localparam int FA_W = $clog2(FA_N);

   typedef struct packed {
      logic [VPPN_W-1:0] vppn;
      logic [ASID_W-1:0] asid;
      logic [LO_W-1:0]   lo0;
      logic [LO_W-1:0]   lo1;
   } sa_ent_t;

   typedef struct packed {
      logic [VPPN_W-1:0] vppn;
      logic [ASID_W-1:0] asid;
      logic [LO_W-1:0]   lo0;
      logic [LO_W-1:0]   lo1;
      logic [PS_W-1:0]   ps;
   } fa_ent_t;

   logic [SA_N-1:0] sa_e;
   logic [FA_N-1:0] fa_e;
   sa_ent_t         sa_mem [SA_N];
   fa_ent_t         fa_mem [FA_N];

   logic wr_in_sa, wr_in_fa, rd_in_sa, rd_in_fa;

   always_comb begin
      wr_in_sa = wr_idx < IDX_W'(SA_N);
      wr_in_fa = !wr_in_sa && (wr_idx < IDX_W'(TOT));
      rd_in_sa = rd_idx < IDX_W'(SA_N);
      rd_in_fa = !rd_in_sa && (rd_idx < IDX_W'(TOT));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sa_e <= '0;
         fa_e <= '0;
      end else begin
         if (wr_in_sa && (wr_en || wr_clr)) sa_e[wr_idx[SA_W-1:0]] <= wr_en;
         if (wr_in_fa && (wr_en || wr_clr)) fa_e[wr_idx[FA_W-1:0]] <= wr_en;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_in_sa) begin
         sa_mem[wr_idx[SA_W-1:0]] <= '{vppn: wr_vppn, asid: wr_asid,
                                       lo0: wr_lo0, lo1: wr_lo1};
      end
      if (wr_en && wr_in_fa) begin
         fa_mem[wr_idx[FA_W-1:0]] <= '{vppn: wr_vppn, asid: wr_asid,
                                       lo0: wr_lo0, lo1: wr_lo1, ps: wr_ps};
      end
   end

   always_comb begin
      rd_e    = 1'b0;
      rd_fa   = rd_in_fa;
      rd_vppn = '0;
      rd_asid = '0;
      rd_lo0  = '0;
      rd_lo1  = '0;
      rd_ps   = '0;
      if (rd_in_sa) begin
         rd_e    = sa_e[rd_idx[SA_W-1:0]];
         rd_vppn = sa_mem[rd_idx[SA_W-1:0]].vppn;
         rd_asid = sa_mem[rd_idx[SA_W-1:0]].asid;
         rd_lo0  = sa_mem[rd_idx[SA_W-1:0]].lo0;
         rd_lo1  = sa_mem[rd_idx[SA_W-1:0]].lo1;
      end else if (rd_in_fa) begin
         rd_e    = fa_e[rd_idx[FA_W-1:0]];
         rd_vppn = fa_mem[rd_idx[FA_W-1:0]].vppn;
         rd_asid = fa_mem[rd_idx[FA_W-1:0]].asid;
         rd_lo0  = fa_mem[rd_idx[FA_W-1:0]].lo0;
         rd_lo1  = fa_mem[rd_idx[FA_W-1:0]].lo1;
         rd_ps   = fa_mem[rd_idx[FA_W-1:0]].ps;
      end
   end
endmodule

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
   import tlbw_pkg::*;
#(
   parameter int WAYS      = DEF_WAYS,
   parameter int SETS      = DEF_SETS,
   parameter int FA_N      = DEF_FA_N,
   parameter int VA_W      = DEF_VA_W,
   parameter int LO_W      = DEF_LO_W,
   parameter int ASID_W    = DEF_ASID_W,
   parameter int PS_W      = DEF_PS_W,
   parameter int PAGE_LSB  = DEF_PAGE_LSB,
   parameter int LFSR_W    = DEF_LFSR_W,
   localparam int IDX_W    = $clog2(WAYS*SETS + FA_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [1:0]        op_code,
   input  logic              refill_mode,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [PS_W-1:0]   shared_ps,
   input  logic [VA_W-1:0]   stg_va,
   input  logic [LO_W-1:0]   stg_lo0,
   input  logic [LO_W-1:0]   stg_lo1,
   input  logic [IDX_W-1:0]  stg_idx,
   input  logic [PS_W-1:0]   stg_ps,
   input  logic              stg_ne,
   input  logic [VA_W-1:0]   rf_va,
   input  logic [LO_W-1:0]   rf_lo0,
   input  logic [LO_W-1:0]   rf_lo1,
   input  logic [PS_W-1:0]   rf_ps,
   output logic              done,
   output logic [IDX_W-1:0]  fill_idx,
   output logic              rd_ne,
   output logic [ASID_W-1:0] rd_asid,
   output logic [VA_W-1:0]   rd_hi,
   output logic [LO_W-1:0]   rd_lo0,
   output logic [LO_W-1:0]   rd_lo1,
   output logic [PS_W-1:0]   rd_ps
);
   localparam int VPPN_W = VA_W - PAGE_LSB;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int FA_W   = $clog2(FA_N);
   localparam int RND_W  = WAY_W + FA_W;

   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_chk_ways
         $error("tlbw_ctrl: WAYS must be a power of two, at least 2");
      end
      if (SETS < 2 || (1 << $clog2(SETS)) != SETS) begin : g_chk_sets
         $error("tlbw_ctrl: SETS must be a power of two, at least 2");
      end
      if (FA_N < 2 || (1 << FA_W) != FA_N || FA_N > WAYS*SETS) begin : g_chk_fa
         $error("tlbw_ctrl: FA_N must be a power of two in 2..WAYS*SETS");
      end
      if (PAGE_LSB < 1 || PAGE_LSB >= VA_W) begin : g_chk_lsb
         $error("tlbw_ctrl: PAGE_LSB out of range");
      end
      if (RND_W > LFSR_W) begin : g_chk_rnd
         $error("tlbw_ctrl: LFSR too narrow for victim selection");
      end
   endgenerate

   tlbw_op_e op;
   logic     is_rd, is_wr, is_fill;

   logic [VA_W-1:0] src_va;
   logic [LO_W-1:0] src_lo0, src_lo1;
   logic [PS_W-1:0] src_ps;

   logic [RND_W-1:0] rnd;
   logic [IDX_W-1:0] victim;

   logic             st_wr_en, st_wr_clr;
   logic [IDX_W-1:0] st_wr_idx;

   logic              s_e, s_fa;
   logic [VPPN_W-1:0] s_vppn;
   logic [ASID_W-1:0] s_asid;
   logic [LO_W-1:0]   s_lo0, s_lo1;
   logic [PS_W-1:0]   s_ps;

   always_comb begin
      op      = tlbw_op_e'(op_code);
      is_rd   = op_valid && (op == OP_READ);
      is_wr   = op_valid && (op == OP_WRITE);
      is_fill = op_valid && (op == OP_FILL);
      src_va  = refill_mode ? rf_va  : stg_va;
      src_lo0 = refill_mode ? rf_lo0 : stg_lo0;
      src_lo1 = refill_mode ? rf_lo1 : stg_lo1;
      src_ps  = refill_mode ? rf_ps  : stg_ps;
      st_wr_en  = is_fill || (is_wr && !stg_ne);
      st_wr_clr = is_wr && stg_ne;
      st_wr_idx = is_fill ? victim : stg_idx;
   end

   tlbw_lfsr #(.LFSR_W(LFSR_W), .OUT_W(RND_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   tlbw_victim #(
      .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .VA_W(VA_W), .PS_W(PS_W)
   ) u_victim (
      .va        (src_va),
      .ps        (src_ps),
      .shared_ps (shared_ps),
      .rnd       (rnd),
      .idx       (victim)
   );

   tlbw_store #(
      .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .VPPN_W(VPPN_W),
      .ASID_W(ASID_W), .LO_W(LO_W), .PS_W(PS_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr_en),
      .wr_clr  (st_wr_clr),
      .wr_idx  (st_wr_idx),
      .wr_vppn (src_va[VA_W-1:PAGE_LSB]),
      .wr_asid (cur_asid),
      .wr_lo0  (src_lo0),
      .wr_lo1  (src_lo1),
      .wr_ps   (src_ps),
      .rd_idx  (stg_idx),
      .rd_e    (s_e),
      .rd_fa   (s_fa),
      .rd_vppn (s_vppn),
      .rd_asid (s_asid),
      .rd_lo0  (s_lo0),
      .rd_lo1  (s_lo1),
      .rd_ps   (s_ps)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         fill_idx <= '0;
         rd_ne    <= 1'b1;
         rd_asid  <= '0;
         rd_hi    <= '0;
         rd_lo0   <= '0;
         rd_lo1   <= '0;
         rd_ps    <= '0;
      end else begin
         done <= is_rd || is_wr || is_fill;
         if (is_fill) fill_idx <= victim;
         if (is_rd) begin
            rd_ne <= !s_e;
            if (s_e) begin
               rd_asid <= s_asid;
               rd_hi   <= {s_vppn, {PAGE_LSB{1'b0}}};
               rd_lo0  <= s_lo0;
               rd_lo1  <= s_lo1;
               rd_ps   <= s_fa ? s_ps : shared_ps;
            end else begin
               rd_asid <= '0;
               rd_hi   <= '0;
               rd_lo0  <= '0;
               rd_lo1  <= '0;
               rd_ps   <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/tlbw_ctrl_chk.sv
module tlbw_ctrl_chk #(
   parameter int WAYS   = 8,
   parameter int SETS   = 256,
   parameter int FA_N   = 64,
   parameter int VA_W   = 48,
   parameter int LO_W   = 64,
   parameter int ASID_W = 10,
   parameter int PS_W   = 6,
   localparam int IDX_W = $clog2(WAYS*SETS + FA_N)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [1:0]        op_code,
   input logic              refill_mode,
   input logic [PS_W-1:0]   stg_ps,
   input logic [PS_W-1:0]   rf_ps,
   input logic [PS_W-1:0]   shared_ps,
   input logic              done,
   input logic [IDX_W-1:0]  fill_idx,
   input logic              rd_ne,
   input logic [ASID_W-1:0] rd_asid,
   input logic [VA_W-1:0]   rd_hi,
   input logic [LO_W-1:0]   rd_lo0,
   input logic [LO_W-1:0]   rd_lo1,
   input logic [PS_W-1:0]   rd_ps
);
   localparam int SA_N = WAYS * SETS;
   localparam int TOT  = SA_N + FA_N;

   logic            accepted, fill_req, read_req;
   logic [PS_W-1:0] req_ps;

   always_comb begin
      accepted = op_valid && (op_code != 2'd3);
      fill_req = op_valid && (op_code == 2'd2);
      read_req = op_valid && (op_code == 2'd0);
      req_ps   = refill_mode ? rf_ps : stg_ps;
   end

   AST_DONE_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
      accepted |=> done);                                           // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !accepted |=> !done);                                         // R2
   AST_SHARED_FILL_IN_SA: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && req_ps == shared_ps) |=> (fill_idx < IDX_W'(SA_N))); // R7
   AST_OTHER_FILL_IN_FA: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && req_ps != shared_ps) |=>
         (fill_idx >= IDX_W'(SA_N) && fill_idx < IDX_W'(TOT)));     // R8
   AST_ABSENT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ne |-> (rd_asid == '0 && rd_hi == '0 && rd_lo0 == '0 &&
                 rd_lo1 == '0 && rd_ps == '0));                     // R4
   AST_READ_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !read_req |=> $stable({rd_ne, rd_asid, rd_hi, rd_lo0, rd_lo1, rd_ps})); // R12
endmodule

bind tlbw_ctrl tlbw_ctrl_chk #(
   .WAYS(WAYS), .SETS(SETS), .FA_N(FA_N), .VA_W(VA_W), .LO_W(LO_W),
   .ASID_W(ASID_W), .PS_W(PS_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .op_code     (op_code),
   .refill_mode (refill_mode),
   .stg_ps      (stg_ps),
   .rf_ps       (rf_ps),
   .shared_ps   (shared_ps),
   .done        (done),
   .fill_idx    (fill_idx),
   .rd_ne       (rd_ne),
   .rd_asid     (rd_asid),
   .rd_hi       (rd_hi),
   .rd_lo0      (rd_lo0),
   .rd_lo1      (rd_lo1),
   .rd_ps       (rd_ps)
);

// File: tb/tlbw_ctrl_bench.sv
module tlbw_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'd0;
   logic        refill_mode = 1'b0;
   logic [9:0]  cur_asid = '0;
   logic [5:0]  shared_ps = 6'd12;
   logic [47:0] stg_va = '0;
   logic [63:0] stg_lo0 = '0, stg_lo1 = '0;
   logic [11:0] stg_idx = '0;
   logic [5:0]  stg_ps = '0;
   logic        stg_ne = 1'b0;
   logic [47:0] rf_va = '0;
   logic [63:0] rf_lo0 = '0, rf_lo1 = '0;
   logic [5:0]  rf_ps = '0;
   logic        done;
   logic [11:0] fill_idx;
   logic        rd_ne;
   logic [9:0]  rd_asid;
   logic [47:0] rd_hi;
   logic [63:0] rd_lo0, rd_lo1;
   logic [5:0]  rd_ps;

   always #(CLK_PERIOD/2) clk = ~clk;

   tlbw_ctrl u_tlbw_ctrl (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .refill_mode(refill_mode), .cur_asid(cur_asid), .shared_ps(shared_ps),
      .stg_va(stg_va), .stg_lo0(stg_lo0), .stg_lo1(stg_lo1),
      .stg_idx(stg_idx), .stg_ps(stg_ps), .stg_ne(stg_ne),
      .rf_va(rf_va), .rf_lo0(rf_lo0), .rf_lo1(rf_lo1), .rf_ps(rf_ps),
      .done(done), .fill_idx(fill_idx), .rd_ne(rd_ne), .rd_asid(rd_asid),
      .rd_hi(rd_hi), .rd_lo0(rd_lo0), .rd_lo1(rd_lo1), .rd_ps(rd_ps)
   );

   typedef enum {K_RD, K_WR, K_FILL} kind_e;
   typedef struct {
      kind_e       kind;
      logic        fill_sa;
      logic [7:0]  set;
      logic        ne;
      logic [9:0]  asid;
      logic [47:0] hi;
      logic [63:0] lo0;
      logic [63:0] lo1;
      logic [5:0]  ps;
      string       req;
   } exp_t;

   exp_t        sb[$];
   int          total = 0;
   int          bad = 0;
   logic [11:0] last_fill = '0;
   bit          finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // monitor: pops the scoreboard whenever the block reports completion
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(0, "R2", "done without request", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (e.kind == K_RD) begin
               chk(rd_ne == e.ne, e.req, "rd_ne", 64'(rd_ne), 64'(e.ne));
               chk(rd_asid == e.asid, e.req, "rd_asid", 64'(rd_asid), 64'(e.asid));
               chk(rd_hi == e.hi, e.req, "rd_hi", 64'(rd_hi), 64'(e.hi));
               chk(rd_lo0 == e.lo0, e.req, "rd_lo0", rd_lo0, e.lo0);
               chk(rd_lo1 == e.lo1, e.req, "rd_lo1", rd_lo1, e.lo1);
               chk(rd_ps == e.ps, e.req, "rd_ps", 64'(rd_ps), 64'(e.ps));
            end else if (e.kind == K_FILL) begin
               last_fill = fill_idx;
               if (e.fill_sa) begin
                  chk(fill_idx < 12'd2048, e.req, "fill in set part",
                      64'(fill_idx), 64'd2047);
                  chk(fill_idx[7:0] == e.set, e.req, "fill set",
                      64'(fill_idx[7:0]), 64'(e.set));
               end else begin
                  chk(fill_idx >= 12'd2048 && fill_idx < 12'd2112, e.req,
                      "fill in assoc part", 64'(fill_idx), 64'd2048);
               end
            end
         end
      end
   end

   task automatic run(input logic [1:0] op, input exp_t e);
      @(posedge clk);
      #1;
      op_code  = op;
      op_valid = 1'b1;
      sb.push_back(e);
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      @(negedge clk);
      #1;
      chk(sb.size() == 0, "R2", "done one cycle after op", 64'(sb.size()), 64'd0);
      sb.delete();
   endtask

   task automatic do_write(input logic [11:0] idx, input logic ne,
                           input logic [47:0] va, input logic [63:0] l0,
                           input logic [63:0] l1, input logic [5:0] ps);
      exp_t e;
      e.kind = K_WR; e.req = "R3";
      stg_idx = idx; stg_ne = ne; stg_va = va;
      stg_lo0 = l0; stg_lo1 = l1; stg_ps = ps;
      run(2'd1, e);
   endtask

   task automatic do_read(input logic [11:0] idx, input logic ne,
                          input logic [9:0] asid, input logic [47:0] va,
                          input logic [63:0] l0, input logic [63:0] l1,
                          input logic [5:0] ps, input string req);
      exp_t e;
      e.kind = K_RD; e.req = req; e.ne = ne;
      e.asid = ne ? 10'd0 : asid;
      e.hi   = ne ? 48'd0 : {va[47:13], 13'd0};
      e.lo0  = ne ? 64'd0 : l0;
      e.lo1  = ne ? 64'd0 : l1;
      e.ps   = ne ? 6'd0 : ps;
      stg_idx = idx;
      run(2'd0, e);
   endtask

   function automatic logic [7:0] set_of(input logic [47:0] va, input logic [5:0] ps);
      logic [47:0] s;
      s = va >> (ps + 6'd1);
      return s[7:0];
   endfunction

   task automatic do_fill(input logic [47:0] va, input logic [5:0] ps,
                          input string req);
      exp_t e;
      e.kind = K_FILL; e.req = req;
      e.fill_sa = (ps == shared_ps);
      e.set = set_of(va, ps);
      run(2'd2, e);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         chk(0, "R2", "watchdog expired", 64'd1, 64'd0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(done == 1'b0, "R1", "done after reset", 64'(done), 64'd0);
      chk(rd_ne == 1'b1, "R1", "rd_ne after reset", 64'(rd_ne), 64'd1);
      chk(rd_hi == '0, "R1", "rd_hi after reset", 64'(rd_hi), 64'd0);
      do_read(12'd0, 1'b1, 0, 0, 0, 0, 0, "R1");
      do_read(12'd2100, 1'b1, 0, 0, 0, 0, 0, "R1");

      // R3 write and read back in the set part
      cur_asid = 10'h3A5;
      do_write(12'd5, 1'b0, 48'h1234_5678_9ABC, 64'hAAAA_0000_1111_2222,
               64'h5555_3333_4444_6666, 6'd9);
      cur_asid = 10'h001;
      do_read(12'd5, 1'b0, 10'h3A5, 48'h1234_5678_9ABC, 64'hAAAA_0000_1111_2222,
              64'h5555_3333_4444_6666, 6'd12, "R3");

      // R5 per-entry page size in assoc part, shared size in set part
      cur_asid = 10'h012;
      do_write(12'd2050, 1'b0, 48'h0000_FFFF_E000, 64'd7, 64'd8, 6'd7);
      do_read(12'd2050, 1'b0, 10'h012, 48'h0000_FFFF_E000, 64'd7, 64'd8, 6'd7, "R5");
      shared_ps = 6'd14;
      do_read(12'd5, 1'b0, 10'h3A5, 48'h1234_5678_9ABC, 64'hAAAA_0000_1111_2222,
              64'h5555_3333_4444_6666, 6'd14, "R5");
      shared_ps = 6'd12;

      // R6 write with not-exists flag clears the entry
      do_write(12'd5, 1'b1, 48'hFFFF_FFFF_FFFF, 64'd1, 64'd2, 6'd3);
      do_read(12'd5, 1'b1, 0, 0, 0, 0, 0, "R6");
      do_read(12'd2050, 1'b0, 10'h012, 48'h0000_FFFF_E000, 64'd7, 64'd8, 6'd7, "R6");

      // R11 out-of-range index
      do_write(12'd2200, 1'b0, 48'h0000_1111_2000, 64'd9, 64'd9, 6'd9);
      do_read(12'd2200, 1'b1, 0, 0, 0, 0, 0, "R11");
      do_write(12'd2111, 1'b0, 48'h0000_2222_4000, 64'd11, 64'd12, 6'd20);
      do_read(12'd2111, 1'b0, 10'h012, 48'h0000_2222_4000, 64'd11, 64'd12, 6'd20, "R11");

      // R7 / R10 fills in the set part, several addresses
      cur_asid = 10'h0C3;
      for (int k = 0; k < 4; k++) begin
         logic [47:0] va;
         va = 48'h0000_00AB_C000 + 48'(k) * 48'h0001_6000;
         stg_va = va; stg_ps = 6'd12; stg_lo0 = 64'(k) + 64'h100;
         stg_lo1 = 64'(k) + 64'h200;
         do_fill(va, 6'd12, "R7");
         do_read(last_fill, 1'b0, 10'h0C3, va, 64'(k) + 64'h100,
                 64'(k) + 64'h200, 6'd12, "R10");
      end

      // R8 / R10 fill with a differing page size
      stg_va = 48'h0000_4000_0000; stg_ps = 6'd21;
      stg_lo0 = 64'hDEAD; stg_lo1 = 64'hBEEF;
      do_fill(48'h0000_4000_0000, 6'd21, "R8");
      do_read(last_fill, 1'b0, 10'h0C3, 48'h0000_4000_0000, 64'hDEAD, 64'hBEEF,
              6'd21, "R10");

      // R9 refill mode sources the rf_* inputs
      refill_mode = 1'b1;
      rf_va = 48'h0000_0003_6000; rf_ps = 6'd12;
      rf_lo0 = 64'h1111; rf_lo1 = 64'h2222;
      stg_va = 48'hFFFF_0000_0000; stg_ps = 6'd30;
      stg_lo0 = 64'h9; stg_lo1 = 64'h9;
      do_fill(48'h0000_0003_6000, 6'd12, "R9");
      do_read(last_fill, 1'b0, 10'h0C3, 48'h0000_0003_6000, 64'h1111, 64'h2222,
              6'd12, "R9");
      rf_va = 48'h0000_0077_8000; rf_ps = 6'd25;
      rf_lo0 = 64'h3333; rf_lo1 = 64'h4444;
      do_write(12'd2060, 1'b0, 48'hFFFF_0000_0000, 64'h9, 64'h9, 6'd30);
      do_read(12'd2060, 1'b0, 10'h0C3, 48'h0000_0077_8000, 64'h3333, 64'h4444,
              6'd25, "R9");
      refill_mode = 1'b0;

      // R12 op code 3 ignored: no done, read outputs held
      @(posedge clk);
      #1;
      op_code = 2'd3; op_valid = 1'b1; stg_idx = 12'd5;
      @(posedge clk);
      #1;
      op_valid = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R12", "done on ignored code", 64'(done), 64'd0);
      chk(rd_lo0 == 64'h3333, "R12", "rd_lo0 held", rd_lo0, 64'h3333);
      chk(rd_ps == 6'd25, "R12", "rd_ps held", 64'(rd_ps), 64'd25);

      repeat (2) @(posedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule